// File: doc/BRIEF.md
# Banked Processor Status Register Unit

This block holds the current status word of a processor core, together with one saved status register for each exception mode that has one. When an exception is taken, the unit stores the current word in the saved register of the mode being entered. It then switches to that mode and raises the interrupt masks.

On an exception return, the unit reloads the current word from the saved register of the mode it is leaving. Software writes replace the whole current word, but only when the mode field in the new value is legal.

The unit also keeps a separate copy of the mode, used for the privilege of instruction fetches. Exception entry and exception return update this copy in the same cycle as the current word. A mode change made by a software write is held back, and a pending flag is raised, until the next barrier, entry or return. Commands arrive as single-cycle strobes. The results appear on the outputs on the clock edge that follows.

Top module: `psr_bank_unit`

## Requirements
- R1: After reset, curWord is 32'h000001D3. This is supervisor mode 5'b10011 in bits [4:0], with masks in bit 8 (abort), bit 7 (interrupt) and bit 6 (fast interrupt) set. After reset, fetchMode is 5'b10011 and fetchPending is 0. The saved registers are not reset.
- R2: A winning entry whose target is a banked mode does three things on the next edge. It copies the old curWord into that mode's saved register. It sets curWord[4:0] to the target and sets bit 7. It also sets bit 6 when the target is fast interrupt 5'b10001. All other bits are kept. The banked modes are 10001, 10010, 10011, 10110, 10111 and 11011.
- R3: An entry whose target is user 5'b10000, system 5'b11111 or an illegal code changes no state.
- R4: A winning return in a banked mode loads curWord from that mode's saved register.
- R5: A return issued in user or system mode changes no state.
- R6: A winning software write with a legal mode field loads curWord from swData and leaves fetchMode unchanged. It sets fetchPending exactly when the new mode differs from fetchMode.
- R7: A software write whose swData[4:0] is not one of the eight legal codes changes no state.
- R8: A winning barrier sets fetchMode to the current mode and clears fetchPending.
- R9: Entry and return update fetchMode to the new mode in the same edge as curWord, and clear fetchPending.
- R10: When several strobes are raised together, only the highest takes effect. The order is entry, then return, then software write, then barrier. A higher strobe blocks the lower ones even when it is itself ignored.
- R11: savedWord shows the saved register of the current mode, and shows zero in user or system mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excEntry | input | 1 | Exception entry strobe |
| excMode | input | 5 | Target mode for entry |
| excReturn | input | 1 | Exception return strobe |
| swWrite | input | 1 | Software status write strobe |
| swData | input | 32 | New status word for a software write |
| barrier | input | 1 | Synchronisation barrier strobe |
| curWord | output | 32 | Current status word |
| fetchMode | output | 5 | Mode used for fetch privilege |
| fetchPending | output | 1 | Software mode change not yet applied to fetchMode |
| savedWord | output | 32 | Saved register of the current mode |

## Verification
The checker assumes that the strobe and operand inputs are never unknown. It also assumes that a return is issued only in a mode whose saved register has been written since power-up, because the saved registers hold no reset value. The stimulus respects both assumptions. Every return is preceded by an entry into the same mode, and savedWord is compared only in states where the register was written earlier in the run. Overlapping strobes are driven on purpose, since the priority rule defines the outcome.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int MODE_W = 5;
  localparam int NUM_BANKS = 6;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_MON = 5'b10110;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam int BIT_ABT_MASK = 8;
  localparam int BIT_IRQ_MASK = 7;
  localparam int BIT_FIQ_MASK = 6;

  typedef struct packed {
    logic entry;
    logic ret;
    logic write;
    logic sync;
  } psrOp_t;

  function automatic logic modeLegal(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_MON, MODE_ABT, MODE_UND, MODE_SYS: modeLegal = 1'b1;
      default: modeLegal = 1'b0;
    endcase
  endfunction

  function automatic logic modeBanked(input logic [MODE_W-1:0] m);
    modeBanked = modeLegal(m) && (m != MODE_USR) && (m != MODE_SYS);
  endfunction

  function automatic logic [BANK_IDX_W-1:0] bankIdx(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: bankIdx = BANK_IDX_W'(0);
      MODE_IRQ: bankIdx = BANK_IDX_W'(1);
      MODE_SVC: bankIdx = BANK_IDX_W'(2);
      MODE_MON: bankIdx = BANK_IDX_W'(3);
      MODE_ABT: bankIdx = BANK_IDX_W'(4);
      default:  bankIdx = BANK_IDX_W'(5);
    endcase
  endfunction
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic              excEntry,
  input  logic [MODE_W-1:0] excMode,
  input  logic              excReturn,
  input  logic              swWrite,
  input  logic [MODE_W-1:0] swMode,
  input  logic              barrier,
  input  logic [MODE_W-1:0] curMode,
  output psrOp_t            op
);
  // Strict priority on raw strobes: a higher strobe masks lower ones even if
  // its own legality check rejects it.
  logic blockReturn, blockWrite, blockSync;

  assign blockReturn = excEntry;
  assign blockWrite  = excEntry | excReturn;
  assign blockSync   = excEntry | excReturn | swWrite;

  always_comb begin
    op.entry = excEntry & modeBanked(excMode);
    op.ret   = excReturn & ~blockReturn & modeBanked(curMode);
    op.write = swWrite & ~blockWrite & modeLegal(swMode);
    op.sync  = barrier & ~blockSync;
  end
endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  psrOp_t            op,
  input  logic [MODE_W-1:0] excMode,
  input  logic [DATA_W-1:0] swData,
  output logic [DATA_W-1:0] curWord,
  output logic [DATA_W-1:0] savedWord
);
  localparam logic [DATA_W-1:0] RESET_WORD =
      DATA_W'((1 << BIT_ABT_MASK) | (1 << BIT_IRQ_MASK) | (1 << BIT_FIQ_MASK))
      | DATA_W'(MODE_SVC);

  logic [DATA_W-1:0] savedBank [NUM_BANKS];
  logic [MODE_W-1:0] curMode;
  logic [DATA_W-1:0] entryWord;

  assign curMode = curWord[MODE_W-1:0];

  always_comb begin
    entryWord = curWord;
    entryWord[MODE_W-1:0] = excMode;
    entryWord[BIT_IRQ_MASK] = 1'b1;
    if (excMode == MODE_FIQ) entryWord[BIT_FIQ_MASK] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          curWord <= RESET_WORD;
    else if (op.entry)  curWord <= entryWord;
    else if (op.ret)    curWord <= savedWord;
    else if (op.write)  curWord <= swData;
  end

  // Saved registers carry no reset value.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    always_ff @(posedge clk) begin
      if (rstN && op.entry && (bankIdx(excMode) == BANK_IDX_W'(b)))
        savedBank[b] <= curWord;
    end
  end

  assign savedWord = modeBanked(curMode) ? savedBank[bankIdx(curMode)] : '0;
endmodule

// File: rtl/psr_fetch_track.sv
module psr_fetch_track
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  psrOp_t            op,
  input  logic [MODE_W-1:0] excMode,
  input  logic [MODE_W-1:0] restoreMode,
  input  logic [MODE_W-1:0] swMode,
  input  logic [MODE_W-1:0] curMode,
  output logic [MODE_W-1:0] fetchMode,
  output logic              fetchPending
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchMode    <= MODE_SVC;
      fetchPending <= 1'b0;
    end else if (op.entry) begin
      fetchMode    <= excMode;
      fetchPending <= 1'b0;
    end else if (op.ret) begin
      fetchMode    <= restoreMode;
      fetchPending <= 1'b0;
    end else if (op.write) begin
      fetchPending <= (swMode != fetchMode);
    end else if (op.sync) begin
      fetchMode    <= curMode;
      fetchPending <= 1'b0;
    end
  end
endmodule

// File: rtl/psr_bank_unit.sv
module psr_bank_unit
  import psr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excEntry,
  input  logic [MODE_W-1:0] excMode,
  input  logic              excReturn,
  input  logic              swWrite,
  input  logic [DATA_W-1:0] swData,
  input  logic              barrier,
  output logic [DATA_W-1:0] curWord,
  output logic [MODE_W-1:0] fetchMode,
  output logic              fetchPending,
  output logic [DATA_W-1:0] savedWord
);
  psrOp_t op;
  logic [MODE_W-1:0] curMode;

  assign curMode = curWord[MODE_W-1:0];

  psr_ctrl uCtrl (
    .excEntry (excEntry),
    .excMode  (excMode),
    .excReturn(excReturn),
    .swWrite  (swWrite),
    .swMode   (swData[MODE_W-1:0]),
    .barrier  (barrier),
    .curMode  (curMode),
    .op       (op)
  );

  psr_datapath #(.DATA_W(DATA_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .op       (op),
    .excMode  (excMode),
    .swData   (swData),
    .curWord  (curWord),
    .savedWord(savedWord)
  );

  psr_fetch_track uFetch (
    .clk         (clk),
    .rstN        (rstN),
    .op          (op),
    .excMode     (excMode),
    .restoreMode (savedWord[MODE_W-1:0]),
    .swMode      (swData[MODE_W-1:0]),
    .curMode     (curMode),
    .fetchMode   (fetchMode),
    .fetchPending(fetchPending)
  );
endmodule

// File: rtl/psr_bank_unit_chk.sv
module psr_bank_unit_chk
  import psr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              excEntry,
  input logic [MODE_W-1:0] excMode,
  input logic              excReturn,
  input logic              swWrite,
  input logic [DATA_W-1:0] swData,
  input logic              barrier,
  input logic [DATA_W-1:0] curWord,
  input logic [MODE_W-1:0] fetchMode,
  input logic              fetchPending,
  input logic [DATA_W-1:0] savedWord
);
  logic entryOk, retOk, writeOnly, writeBad, syncOnly, noBank;

  assign entryOk   = excEntry && modeBanked(excMode);
  assign retOk     = excReturn && !excEntry && modeBanked(curWord[MODE_W-1:0]);
  assign writeOnly = swWrite && !excEntry && !excReturn;
  assign writeBad  = writeOnly && !modeLegal(swData[MODE_W-1:0]);
  assign syncOnly  = barrier && !excEntry && !excReturn && !swWrite;
  assign noBank    = !modeBanked(curWord[MODE_W-1:0]);

  AST_ENTRY_COPY: assert property (@(posedge clk) disable iff (!rstN)
    entryOk |=> savedWord == $past(curWord)); // R2
  AST_ENTRY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (excEntry && !entryOk) |=> $stable(curWord) && $stable(fetchMode)); // R3
  AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    retOk |=> curWord == $past(savedWord)); // R4
  AST_NOBANK_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (excReturn && !excEntry && noBank) |=> $stable(curWord)); // R5
  AST_WRITE_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    writeOnly |=> $stable(fetchMode)); // R6
  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    writeBad |=> $stable(curWord) && $stable(fetchPending)); // R7
  AST_MODE_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    modeLegal(curWord[MODE_W-1:0])); // R7
  AST_BARRIER_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    syncOnly |=> (fetchMode == curWord[MODE_W-1:0]) && !fetchPending); // R8
  AST_EXC_FETCH_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (entryOk || retOk) |=> (fetchMode == curWord[MODE_W-1:0]) && !fetchPending); // R9
  AST_NOT_PENDING_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    !fetchPending |-> fetchMode == curWord[MODE_W-1:0]); // R6
  AST_NOBANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    noBank |-> savedWord == '0); // R11
endmodule

bind psr_bank_unit psr_bank_unit_chk #(.DATA_W(DATA_W)) uChk (.*);

// File: tb/tb_psr_bank_unit.sv
module tb_psr_bank_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        excEntry, excReturn, swWrite, barrier;
  logic [4:0]  excMode;
  logic [31:0] swData;
  logic [31:0] curWord, savedWord;
  logic [4:0]  fetchMode;
  logic        fetchPending;

  int checks = 0;
  int errors = 0;
  bit timedOut = 0;

  always #4 clk = ~clk;

  psr_bank_unit dut (.*);

  // strobes {entry,ret,write,barrier}, excMode, swData,
  // expCur, expFetch, expPend, checkSaved, expSaved
  typedef struct packed {
    logic [3:0]  stb;
    logic [4:0]  eMode;
    logic [31:0] data;
    logic [31:0] expCur;
    logic [4:0]  expFetch;
    logic        expPend;
    logic        chkSaved;
    logic [31:0] expSaved;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'b0010, 5'h00, 32'h8000011F, 32'h8000011F, 5'h13, 1'b1, 1'b1, 32'h0},        // R6 to system, pending
    '{4'b0001, 5'h00, 32'h0,        32'h8000011F, 5'h1F, 1'b0, 1'b1, 32'h0},        // R8 barrier
    '{4'b1000, 5'h12, 32'h0,        32'h80000192, 5'h12, 1'b0, 1'b1, 32'h8000011F}, // R2 R9 entry irq
    '{4'b0010, 5'h00, 32'h400001D2, 32'h400001D2, 5'h12, 1'b0, 1'b1, 32'h8000011F}, // R6 same mode
    '{4'b1000, 5'h11, 32'h0,        32'h400001D1, 5'h11, 1'b0, 1'b1, 32'h400001D2}, // R2 entry fiq
    '{4'b0100, 5'h00, 32'h0,        32'h400001D2, 5'h12, 1'b0, 1'b1, 32'h8000011F}, // R4 R9 return
    '{4'b0010, 5'h00, 32'h00000015, 32'h400001D2, 5'h12, 1'b0, 1'b1, 32'h8000011F}, // R7 illegal
    '{4'b0010, 5'h00, 32'h00000017, 32'h00000017, 5'h12, 1'b1, 1'b0, 32'h0},        // R6 to abort
    '{4'b1010, 5'h1B, 32'h00000010, 32'h0000009B, 5'h1B, 1'b0, 1'b1, 32'h00000017}, // R10 entry beats write
    '{4'b0101, 5'h00, 32'h0,        32'h00000017, 5'h17, 1'b0, 1'b0, 32'h0},        // R10 return beats barrier
    '{4'b1000, 5'h10, 32'h0,        32'h00000017, 5'h17, 1'b0, 1'b0, 32'h0},        // R3 user target
    '{4'b0010, 5'h00, 32'h00000010, 32'h00000010, 5'h17, 1'b1, 1'b1, 32'h0},        // R6 to user, R11
    '{4'b0100, 5'h00, 32'h0,        32'h00000010, 5'h17, 1'b1, 1'b1, 32'h0},        // R5 return in user
    '{4'b0001, 5'h00, 32'h0,        32'h00000010, 5'h10, 1'b0, 1'b1, 32'h0}         // R8 barrier
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    excEntry = 0; excReturn = 0; swWrite = 0; barrier = 0;
    excMode = 5'h0; swData = 32'h0;
  endtask

  initial begin
    #1500000;
    timedOut = 1;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearIn();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 curWord", curWord, 32'h000001D3);
    chk("R1 fetchMode", {27'h0, fetchMode}, 32'h13);
    chk("R1 fetchPending", {31'h0, fetchPending}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      {excEntry, excReturn, swWrite, barrier} = VECS[i].stb;
      excMode = VECS[i].eMode;
      swData  = VECS[i].data;
      @(negedge clk);
      clearIn();
      chk($sformatf("R2-table v%0d curWord", i), curWord, VECS[i].expCur);
      chk($sformatf("R9-table v%0d fetchMode", i), {27'h0, fetchMode}, {27'h0, VECS[i].expFetch});
      chk($sformatf("R6-table v%0d pending", i), {31'h0, fetchPending}, {31'h0, VECS[i].expPend});
      if (VECS[i].chkSaved)
        chk($sformatf("R11 v%0d savedWord", i), savedWord, VECS[i].expSaved);
    end

    // R10: an ignored return in user mode still blocks a write and a barrier
    excReturn = 1; swWrite = 1; swData = 32'h00000013; barrier = 1;
    @(negedge clk);
    clearIn();
    chk("R10 blocked write", curWord, 32'h00000010);
    chk("R10 blocked barrier", {27'h0, fetchMode}, 32'h10);

    // R2/R4 monitor mode round trip with fetch following at once (R9)
    excEntry = 1; excMode = 5'h16;
    @(negedge clk);
    clearIn();
    chk("R2 monitor entry", curWord, 32'h00000096);
    chk("R9 monitor fetch", {27'h0, fetchMode}, 32'h16);
    chk("R11 monitor saved", savedWord, 32'h00000010);
    excReturn = 1;
    @(negedge clk);
    clearIn();
    chk("R4 monitor return", curWord, 32'h00000010);
    chk("R9 return fetch", {27'h0, fetchMode}, 32'h10);

    // R1 reset again from a non-reset state
    swWrite = 1; swData = 32'h0000001F;
    @(negedge clk);
    clearIn();
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    chk("R1 reapplied curWord", curWord, 32'h000001D3);
    chk("R1 reapplied fetchMode", {27'h0, fetchMode}, 32'h13);
    chk("R1 reapplied pending", {31'h0, fetchPending}, 32'h0);

    if (!timedOut) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule